// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Periodic Interrupt

This block is a timebase for a microcontroller-class chip. It keeps an up-counter that runs without stopping. The counter advances on ticks taken from the bus clock through a prescaler with four settings. Software can read the count but can never load it. The live count also leaves the block on a port, so compare and capture logic elsewhere can use it.

Next to the counter sits a separate divider that raises a periodic flag. The divider has four selectable periods, and each period is twice the one before it. Each of the two flags has a mask bit. A single interrupt line is asserted whenever a set flag has its mask bit enabled.

Software uses a small byte-wide register window with four addresses:

| Address | Contents |
|---|---|
| 0 | Count, upper byte |
| 1 | Count, lower byte |
| 2 | Control |
| 3 | Status |

The prescale choice can be changed only in a short window after reset. After that window closes, it is fixed.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count is zero, the control register reads 0x00, both status flags are clear and `irq` is low.
- R2: The count advances by one on each prescaled tick. The prescale field is control bits [1:0], and its values 0, 1, 2 and 3 give one tick every 1, 4, 8 or 16 bus clocks. The control register reads back the values that were written to it.
- R3: The count is read at address 0 (upper byte, zero-extended to 16 bits) and address 1 (lower byte). The same value drives the `count` port. Writes to address 0 or 1 leave the count and its rate unchanged.
- R4: A write to the prescale field takes effect only during the first LOCK_CYCLES clocks after reset. Later writes leave the field and the tick rate unchanged, while the other control bits still update.
- R5: The overflow flag (status bit 0) sets on the tick that moves the count from all ones to zero, and at no other time.
- R6: The periodic flag (status bit 1) sets once every 2^(RTI_BASE_LOG2 + rate) bus clocks. The rate field is control bits [3:2], and the flag keeps recurring.
- R7: Writing a 1 to a status bit at address 3 clears that flag. A 0 leaves the flag unchanged. If a new event arrives in the same cycle as the clear, the flag stays set.
- R8: `irq` is high exactly when the overflow flag is set with control bit 4 set, or the periodic flag is set with control bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| count | output | CNT_W | Live counter value |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The bench builds the block with an 8-bit counter and a periodic base of 2^4 clocks, and keeps LOCK_CYCLES at 64. With these values, a counter wrap takes 256 clocks and the slowest periodic rate takes 128 clocks. Every flag event can therefore be observed many times within a short run. The 64-clock lock window is kept at its real size, so writes can be placed on either side of it.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W         = 16,
  parameter int RTI_BASE_LOG2 = 13,
  parameter int LOCK_CYCLES   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam int RTI_W = RTI_BASE_LOG2 + 3;
  localparam int AGE_W = $clog2(LOCK_CYCLES + 1);

  logic [1:0]       psel, rsel;
  logic             ovf_mask, per_mask, ovf_flag, per_flag;
  logic [3:0]       pre_cnt, pre_lim;
  logic [AGE_W-1:0] age;
  logic [RTI_W-1:0] rti_cnt, rti_mask;
  logic [15:0]      cnt_pad;

  wire win_open = age < AGE_W'(LOCK_CYCLES);
  wire tick     = pre_cnt >= pre_lim;
  wire wrap     = tick && (&count);
  wire wr_ctrl  = wr_en && addr == 2'd2;
  wire wr_stat  = wr_en && addr == 2'd3;

  always_comb begin
    case (psel)
      2'd0:    pre_lim = 4'd0;
      2'd1:    pre_lim = 4'd3;
      2'd2:    pre_lim = 4'd7;
      default: pre_lim = 4'd15;
    endcase
  end

  assign rti_mask = (RTI_W'(1) << (RTI_BASE_LOG2 + 32'(rsel))) - RTI_W'(1);
  wire per_hit = (rti_cnt & rti_mask) == rti_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      pre_cnt <= '0;
      count   <= '0;
      rti_cnt <= '0;
    end else begin
      if (win_open) age <= age + 1'b1;
      pre_cnt <= tick ? 4'd0 : pre_cnt + 4'd1;
      if (tick) count <= count + 1'b1;
      rti_cnt <= rti_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psel     <= 2'd0;
      rsel     <= 2'd0;
      ovf_mask <= 1'b0;
      per_mask <= 1'b0;
    end else if (wr_ctrl) begin
      if (win_open) psel <= wdata[1:0];
      rsel     <= wdata[3:2];
      ovf_mask <= wdata[4];
      per_mask <= wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      per_flag <= 1'b0;
    end else begin
      if (wrap)                      ovf_flag <= 1'b1;
      else if (wr_stat && wdata[0])  ovf_flag <= 1'b0;
      if (per_hit)                   per_flag <= 1'b1;
      else if (wr_stat && wdata[1])  per_flag <= 1'b0;
    end
  end

  assign cnt_pad = 16'(count);

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt_pad[15:8];
      2'd1:    rdata = cnt_pad[7:0];
      2'd2:    rdata = {2'b00, per_mask, ovf_mask, rsel, psel};
      default: rdata = {6'b0, per_flag, ovf_flag};
    endcase
  end

  assign irq = (ovf_flag && ovf_mask) || (per_flag && per_mask);
endmodule

// File: rtl/prescaled_timer_checks.sv
module prescaled_timer_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             ovf_flag,
  input logic             per_flag,
  input logic [1:0]       psel,
  input logic             win_open
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1'b1));

  p_prescale_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(win_open) |-> $stable(psel));

  p_wrap_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && $past(count) == '1) |-> ovf_flag);

  p_ovf_holds_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf_flag) && !($past(wr_en) && $past(addr) == 2'd3 && $past(wdata[0])))
      |-> ovf_flag);

  p_per_holds_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(per_flag) && !($past(wr_en) && $past(addr) == 2'd3 && $past(wdata[1])))
      |-> per_flag);

  p_quiet_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !per_flag) |-> !irq);
endmodule

bind prescaled_timer prescaled_timer_checks #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .count(count), .irq(irq), .ovf_flag(ovf_flag), .per_flag(per_flag),
  .psel(psel), .win_open(win_open)
);

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
  localparam int CW = 8;
  localparam int BASE = 4;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic [CW-1:0] count;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  localparam int VEC [6][3] = '{'{0, 40, 40}, '{1, 40, 10}, '{2, 40, 5},
                                '{3, 48, 3},  '{3, 32, 2},  '{0, 100, 100}};

  prescaled_timer #(.CNT_W(CW), .RTI_BASE_LOG2(BASE), .LOCK_CYCLES(64)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .count(count), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_bit(input int b, output int t);
    logic [7:0] s;
    for (int i = 0; i < 1000; i++) begin
      rd(2'd3, s);
      if (s[b]) begin t = cyc; return; end
      @(negedge clk);
    end
    check("R6 flag timeout", 0, 1);
    t = cyc;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, c0, c1;
    int t1, t2;

    // R1 reset state
    do_reset();
    rd(2'd0, d); check("R1 count hi", d, 0);
    rd(2'd1, d); check("R1 count lo", d, 0);
    rd(2'd2, d); check("R1 ctrl", d, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    check("R1 irq", irq, 0);

    // R2 prescale vectors
    foreach (VEC[i]) begin
      do_reset();
      wr(2'd2, 8'(VEC[i][0]));
      rd(2'd2, d); check("R2 ctrl readback", d, VEC[i][0]);
      rd(2'd1, c0);
      repeat (VEC[i][1]) @(negedge clk);
      rd(2'd1, c1);
      check("R2 tick rate", 8'(c1 - c0), VEC[i][2]);
    end

    // R4 within window later write wins, after window ignored
    do_reset();
    wr(2'd2, 8'h01); wr(2'd2, 8'h03);
    rd(2'd2, d); check("R4 in-window write", d, 3);
    do_reset();
    repeat (70) @(negedge clk);
    wr(2'd2, 8'h13);
    rd(2'd2, d); check("R4 late prescale ignored", d[1:0], 0);
    check("R4 other bits update", d[4], 1);
    rd(2'd1, c0);
    repeat (20) @(negedge clk);
    rd(2'd1, c1); check("R4 rate unchanged", 8'(c1 - c0), 20);

    // R3 count not writable
    rd(2'd1, c0);
    wr(2'd1, 8'h55);
    wr(2'd0, 8'hAA);
    rd(2'd1, c1); check("R3 write to count ignored", 8'(c1 - c0), 2);
    rd(2'd0, d); check("R3 upper byte", d, 0);
    rd(2'd1, d); check("R3 port matches", count, d);

    // R5 / R7 / R8 overflow
    do_reset();
    for (int i = 0; i < 300; i++) begin
      rd(2'd1, d);
      if (d == 8'hFF) break;
      @(negedge clk);
    end
    rd(2'd3, d); check("R5 no flag before wrap", d[0], 0);
    @(negedge clk);
    rd(2'd1, d); check("R5 wrapped to zero", d, 0);
    rd(2'd3, d); check("R5 flag on wrap", d[0], 1);
    check("R8 masked irq low", irq, 0);
    wr(2'd2, 8'h10);
    #1 check("R8 ovf irq", irq, 1);
    wr(2'd3, 8'h00);
    rd(2'd3, d); check("R7 zero write no effect", d[0], 1);
    wr(2'd3, 8'h01);
    rd(2'd3, d); check("R7 clear by one", d[0], 0);
    check("R8 irq drops", irq, 0);

    // R6 periodic rates
    for (int r = 0; r < 4; r++) begin
      do_reset();
      wr(2'd2, 8'(r << 2));
      wait_bit(1, t1);
      wr(2'd3, 8'h02);
      rd(2'd3, d); check("R7 periodic clear", d[1], 0);
      wait_bit(1, t2);
      check("R6 period", t2 - t1, 16 << r);
      if (r == 3) begin
        check("R8 periodic masked", irq, 0);
        wr(2'd2, 8'(8'h20 | (r << 2)));
        #1 check("R8 periodic irq", irq, 1);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule